// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block holds the processor-target fields of an interrupt distributor, one 8-bit field per interrupt line. A register bus with byte and 32-bit word accesses reaches it, and each request carries the ID of the CPU that issued it. The first 32 lines are private to each CPU and read-only. The block keeps no storage for them. It forms their value at read time from the requesting CPU's ID. Lines from 32 up to the implemented count are shared and writable, held in a flat array indexed by line minus 32.

A target field can be read in one of two ways, chosen by a parameter. In mask mode, bit N set means CPU N is a target. In number mode, the field holds a single CPU number. The block also takes shared peripheral interrupts, looks up the field of the line that fired, and emits a pending-set request carrying that field. It flags line numbers that cannot be injected, and in mask mode it flags masks with more than one bit set.

A combinational query port tells whether a given CPU is a target of a given line. Every write that reaches shared storage raises a one-cycle update hint that carries the word-group index of the written line.

Top module: `irq_target_bank`

## Requirements
- R1: Reset clears every shared target field to zero and drives bus_rvalid, upd_valid and pend_valid low. A word read of line 32 after reset returns 0x00000000.
- R2: A read of a line below 32 returns a value formed from bus_cpu. In mask mode (ALT_MODE=0) the value is 1<<bus_cpu. In number mode (ALT_MODE=1) it is the CPU number. The same value appears in every byte lane of a word read.
- R3: Writes to lines 0 to 31 have no effect. A later read of those lines still returns the value formed from the reader's ID.
- R4: A byte access (bus_word=0) reads or writes only the field of line bus_addr, in bits 7:0 of the data. The upper 24 read bits are zero.
- R5: A word access (bus_word=1) clears bus_addr[1:0] and covers four lines. The lowest line sits in bits 7:0, then 15:8, then 23:16, and the highest line in 31:24.
- R6: Lines at or above NUM_LINES read as zero, and writes to them are ignored.
- R7: One cycle after a write that touches at least one shared, implemented line, upd_valid is 1 and upd_hint equals the aligned line index shifted right by 2. A write that touches no such line leaves upd_valid at 0.
- R8: A request with bus_cpu >= NUM_CPUS returns bus_err=1 with bus_rdata zero, and changes no field.
- R9: A peripheral interrupt whose number is below 32 or at or above NUM_LINES sets spi_err_range one cycle later, and pend_valid stays 0.
- R10: For a peripheral interrupt on a shared line, one cycle later pend_valid=1, pend_num is the line, and pend_target is the line's field. The exception is mask mode with more than one bit set in the field (field & (field-1) != 0). In that case spi_err_multi=1 and pend_valid=0. Number mode never raises spi_err_multi.
- R11: qry_hit is 1 when bit qry_cpu of the field of line qry_num is set (mask mode), or when the field equals qry_cpu (number mode). With NUM_CPUS=1, qry_hit is always 1.
- R12: Every bus request is answered by bus_rvalid=1 exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit word, 0 = byte |
| bus_cpu | input | CPU_ID_W | ID of requesting CPU |
| bus_addr | input | ADDR_W | Line index (byte offset into the field array) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response strobe, one cycle after request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | CPU ID out of range |
| upd_valid | output | 1 | Shared target state changed |
| upd_hint | output | ADDR_W-2 | Word-group index of the written line |
| spi_valid | input | 1 | Peripheral interrupt strobe |
| spi_num | input | ADDR_W | Peripheral interrupt line |
| pend_valid | output | 1 | Pending-set request |
| pend_target | output | 8 | Target field of the pending line |
| pend_num | output | ADDR_W | Line to mark pending |
| spi_err_range | output | 1 | Injected line not injectable |
| spi_err_multi | output | 1 | Mask has several targets (mask mode) |
| qry_cpu | input | CPU_ID_W | CPU to test |
| qry_num | input | ADDR_W | Line to test |
| qry_hit | output | 1 | CPU is a target of the line |

## Verification
The bench exercises the bus with byte and word accesses on four kinds of line: private, shared, aligned and unaligned word addresses, and lines beyond the implemented count. These patterns separate a computed private value from a stored one, correct lane packing from swapped lanes, and cleared address bits from uncleared ones. Writes to private lines, writes beyond the implemented count, and writes with a bad CPU ID are each followed by read-backs, which show whether the ignored write leaked into storage. A mask-mode instance and a number-mode instance receive the same peripheral interrupts and queries, including a two-bit field, so the multi-target check and the equality test are told apart from the bit test. A single-CPU instance confirms that target filtering is bypassed.

// File: rtl/itb_pkg.sv
package itb_pkg;
   typedef enum logic {ACC_BYTE = 1'b0, ACC_WORD = 1'b1} acc_e;
   localparam int LANES = 4;
endpackage

// File: rtl/itb_lane_view.sv
module itb_lane_view #(
   parameter int NUM_LINES  = 64,
   parameter int PRIV_LINES = 32,
   parameter int FIELD_W    = 8,
   parameter int CPU_ID_W   = 3,
   parameter int LINE_W     = 10,
   parameter bit ALT_MODE   = 1'b0,
   localparam int SH   = NUM_LINES - PRIV_LINES,
   localparam int SH_W = (SH > 1) ? $clog2(SH) : 1
) (
   input  logic [SH-1:0][FIELD_W-1:0] fields,
   input  logic [LINE_W-1:0]          line,
   input  logic [CPU_ID_W-1:0]        cpu,
   output logic [FIELD_W-1:0]         field
);
   logic [FIELD_W-1:0] priv_val;
   logic [LINE_W-1:0]  off;
   logic [SH_W-1:0]    idx;

   generate
      if (ALT_MODE) begin : g_num
         assign priv_val = FIELD_W'(cpu);
      end else begin : g_mask
         assign priv_val = FIELD_W'(1) << cpu;
      end
   endgenerate

   assign off = line - LINE_W'(PRIV_LINES);
   assign idx = off[SH_W-1:0];

   always_comb begin
      if (line < LINE_W'(PRIV_LINES))
         field = priv_val;
      else if (line < LINE_W'(NUM_LINES))
         field = fields[idx];
      else
         field = '0;
   end
endmodule

// File: rtl/itb_field_store.sv
module itb_field_store #(
   parameter int SH         = 32,
   parameter int FIELD_W    = 8,
   parameter int PRIV_LINES = 32,
   parameter int LINE_W     = 10
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_valid,
   input  logic [LINE_W-1:0]                     wr_base,
   input  logic [itb_pkg::LANES-1:0]             wr_lanes,
   input  logic [itb_pkg::LANES*FIELD_W-1:0]     wr_data,
   output logic [SH-1:0][FIELD_W-1:0]            fields
);
   localparam int L = itb_pkg::LANES;

   genvar j;
   generate
      for (j = 0; j < SH; j++) begin : g_fld
         localparam logic [LINE_W-1:0] MY_LINE = LINE_W'(j + PRIV_LINES);
         logic               hit;
         logic [FIELD_W-1:0] dat;
         logic [FIELD_W-1:0] q;

         always_comb begin
            hit = 1'b0;
            dat = '0;
            for (int l = 0; l < L; l++) begin
               if (wr_lanes[l] && (wr_base + LINE_W'(l)) == MY_LINE) begin
                  hit = 1'b1;
                  dat = wr_data[l*FIELD_W +: FIELD_W];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_valid && hit)
               q <= dat;
         end

         assign fields[j] = q;
      end
   endgenerate

   // R4
   first_field_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_lanes == 4'h1 && wr_base == LINE_W'(PRIV_LINES))
      |=> fields[0] == $past(wr_data[FIELD_W-1:0]));
endmodule

// File: rtl/itb_spi_route.sv
module itb_spi_route #(
   parameter int NUM_LINES  = 64,
   parameter int PRIV_LINES = 32,
   parameter int FIELD_W    = 8,
   parameter int LINE_W     = 10,
   parameter bit ALT_MODE   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_valid,
   input  logic [LINE_W-1:0]  spi_num,
   input  logic [FIELD_W-1:0] field,
   output logic               pend_valid,
   output logic [FIELD_W-1:0] pend_target,
   output logic [LINE_W-1:0]  pend_num,
   output logic               err_range,
   output logic               err_multi
);
   logic in_range;
   logic multi;

   assign in_range = (spi_num >= LINE_W'(PRIV_LINES)) && (spi_num < LINE_W'(NUM_LINES));

   generate
      if (ALT_MODE) begin : g_num
         assign multi = 1'b0;
      end else begin : g_mask
         assign multi = |(field & (field - FIELD_W'(1)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid  <= 1'b0;
         pend_target <= '0;
         pend_num    <= '0;
         err_range   <= 1'b0;
         err_multi   <= 1'b0;
      end else begin
         pend_valid  <= spi_valid && in_range && !multi;
         err_range   <= spi_valid && !in_range;
         err_multi   <= spi_valid && in_range && multi;
         pend_target <= (spi_valid && in_range) ? field : '0;
         pend_num    <= spi_valid ? spi_num : '0;
      end
   end

   // R9
   pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_valid && (err_range || err_multi)));

   // R9
   low_line_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_valid && spi_num < LINE_W'(PRIV_LINES)) |=> !pend_valid);

   generate
      if (!ALT_MODE) begin : g_mask_chk
         // R10
         pend_single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_valid |-> $onehot0(pend_target));
      end
   endgenerate
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
   parameter int NUM_CPUS   = 4,
   parameter int NUM_LINES  = 64,
   parameter int PRIV_LINES = 32,
   parameter int FIELD_W    = 8,
   parameter int CPU_ID_W   = 3,
   parameter int ADDR_W     = 10,
   parameter bit ALT_MODE   = 1'b0,
   localparam int SH     = NUM_LINES - PRIV_LINES,
   localparam int LANES  = itb_pkg::LANES,
   localparam int DATA_W = LANES * FIELD_W,
   localparam int HINT_W = ADDR_W - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic                bus_word,
   input  logic [CPU_ID_W-1:0] bus_cpu,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                bus_rvalid,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_err,
   output logic                upd_valid,
   output logic [HINT_W-1:0]   upd_hint,
   input  logic                spi_valid,
   input  logic [ADDR_W-1:0]   spi_num,
   output logic                pend_valid,
   output logic [FIELD_W-1:0]  pend_target,
   output logic [ADDR_W-1:0]   pend_num,
   output logic                spi_err_range,
   output logic                spi_err_multi,
   input  logic [CPU_ID_W-1:0] qry_cpu,
   input  logic [ADDR_W-1:0]   qry_num,
   output logic                qry_hit
);
   import itb_pkg::*;

   generate
      if (FIELD_W != 8) begin : g_bad_field
         $error("target field must be one byte lane");
      end
      if (NUM_LINES % LANES != 0 || NUM_LINES <= PRIV_LINES) begin : g_bad_lines
         $error("line count must be a multiple of four above the private lines");
      end
      if (NUM_LINES > (1 << ADDR_W)) begin : g_bad_addr
         $error("address too narrow for line count");
      end
      if (NUM_CPUS < 1 || NUM_CPUS > (1 << CPU_ID_W)) begin : g_bad_cpu
         $error("CPU count does not fit the ID width");
      end
      if (!ALT_MODE && NUM_CPUS > FIELD_W) begin : g_bad_mask
         $error("mask mode needs one field bit per CPU");
      end
   endgenerate

   acc_e                         acc;
   logic                         cpu_ok;
   logic                         wr_ok;
   logic [ADDR_W-1:0]            base;
   logic [LANES-1:0]             lanes;
   logic [LANES-1:0]             touch;
   logic [SH-1:0][FIELD_W-1:0]   fields;
   logic [LANES-1:0][FIELD_W-1:0] lane_val;
   logic [DATA_W-1:0]            rd_word;
   logic [FIELD_W-1:0]           spi_field;
   logic [FIELD_W-1:0]           qry_field;

   assign acc    = bus_word ? ACC_WORD : ACC_BYTE;
   assign cpu_ok = {1'b0, bus_cpu} < (CPU_ID_W+1)'(NUM_CPUS);
   assign wr_ok  = bus_valid && bus_write && cpu_ok;
   assign base   = (acc == ACC_WORD) ? {bus_addr[ADDR_W-1:2], 2'b00} : bus_addr;
   assign lanes  = (acc == ACC_WORD) ? {LANES{1'b1}} : LANES'(1);

   genvar l;
   generate
      for (l = 0; l < LANES; l++) begin : g_lane
         logic [ADDR_W-1:0] line;
         assign line = base + ADDR_W'(l);
         assign touch[l] = lanes[l] && (line >= ADDR_W'(PRIV_LINES)) &&
                           (line < ADDR_W'(NUM_LINES));
         itb_lane_view #(
            .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .FIELD_W(FIELD_W),
            .CPU_ID_W(CPU_ID_W), .LINE_W(ADDR_W), .ALT_MODE(ALT_MODE)
         ) u_view (
            .fields(fields), .line(line), .cpu(bus_cpu), .field(lane_val[l])
         );
      end
   endgenerate

   assign rd_word = (acc == ACC_WORD) ? DATA_W'(lane_val) : DATA_W'(lane_val[0]);

   itb_field_store #(
      .SH(SH), .FIELD_W(FIELD_W), .PRIV_LINES(PRIV_LINES), .LINE_W(ADDR_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_ok), .wr_base(base),
      .wr_lanes(lanes), .wr_data(bus_wdata), .fields(fields)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
         bus_err    <= 1'b0;
         upd_valid  <= 1'b0;
         upd_hint   <= '0;
      end else begin
         bus_rvalid <= bus_valid;
         bus_err    <= bus_valid && !cpu_ok;
         bus_rdata  <= (bus_valid && !bus_write && cpu_ok) ? rd_word : '0;
         upd_valid  <= wr_ok && (|touch);
         upd_hint   <= base[ADDR_W-1:2];
      end
   end

   itb_lane_view #(
      .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .FIELD_W(FIELD_W),
      .CPU_ID_W(CPU_ID_W), .LINE_W(ADDR_W), .ALT_MODE(ALT_MODE)
   ) u_spi_view (
      .fields(fields), .line(spi_num), .cpu('0), .field(spi_field)
   );

   itb_spi_route #(
      .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .FIELD_W(FIELD_W),
      .LINE_W(ADDR_W), .ALT_MODE(ALT_MODE)
   ) u_spi (
      .clk(clk), .rst_n(rst_n), .spi_valid(spi_valid), .spi_num(spi_num),
      .field(spi_field), .pend_valid(pend_valid), .pend_target(pend_target),
      .pend_num(pend_num), .err_range(spi_err_range), .err_multi(spi_err_multi)
   );

   itb_lane_view #(
      .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .FIELD_W(FIELD_W),
      .CPU_ID_W(CPU_ID_W), .LINE_W(ADDR_W), .ALT_MODE(ALT_MODE)
   ) u_qry_view (
      .fields(fields), .line(qry_num), .cpu(qry_cpu), .field(qry_field)
   );

   generate
      if (NUM_CPUS == 1) begin : g_single
         assign qry_hit = 1'b1;
      end else if (ALT_MODE) begin : g_num
         assign qry_hit = (qry_field == FIELD_W'(qry_cpu));
      end else begin : g_mask
         assign qry_hit = qry_field[qry_cpu];
      end
   endgenerate

   // R12
   resp_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> bus_rvalid);

   // R8
   bad_cpu_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !cpu_ok) |=> (bus_err && !upd_valid && bus_rdata == '0));

   // R8
   bad_cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !cpu_ok) |=> $stable(fields));

   // R7
   upd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> $past(bus_valid && bus_write));
endmodule

// File: tb/irq_target_bank_bench.sv
module irq_target_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
   logic [2:0]  bus_cpu = '0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        spi_valid = 1'b0;
   logic [9:0]  spi_num = '0;
   logic [2:0]  qry_cpu = '0;
   logic [9:0]  qry_num = '0;

   logic        m_rvalid, m_err, m_upd, m_pend, m_erng, m_emul, m_hit;
   logic [31:0] m_rdata;
   logic [7:0]  m_hint, m_ptgt;
   logic [9:0]  m_pnum;
   logic        a_rvalid, a_err, a_upd, a_pend, a_erng, a_emul, a_hit;
   logic [31:0] a_rdata;
   logic [7:0]  a_hint, a_ptgt;
   logic [9:0]  a_pnum;
   logic        s_rvalid, s_err, s_upd, s_pend, s_erng, s_emul, s_hit;
   logic [31:0] s_rdata;
   logic [7:0]  s_hint, s_ptgt;
   logic [9:0]  s_pnum;

   always #2 clk = ~clk;

   irq_target_bank #(.NUM_CPUS(4), .ALT_MODE(1'b0)) u_irq_target_bank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(m_rvalid), .bus_rdata(m_rdata), .bus_err(m_err),
      .upd_valid(m_upd), .upd_hint(m_hint), .spi_valid(spi_valid), .spi_num(spi_num),
      .pend_valid(m_pend), .pend_target(m_ptgt), .pend_num(m_pnum),
      .spi_err_range(m_erng), .spi_err_multi(m_emul),
      .qry_cpu(qry_cpu), .qry_num(qry_num), .qry_hit(m_hit));

   irq_target_bank #(.NUM_CPUS(4), .ALT_MODE(1'b1)) u_irq_target_bank_alt (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(a_rvalid), .bus_rdata(a_rdata), .bus_err(a_err),
      .upd_valid(a_upd), .upd_hint(a_hint), .spi_valid(spi_valid), .spi_num(spi_num),
      .pend_valid(a_pend), .pend_target(a_ptgt), .pend_num(a_pnum),
      .spi_err_range(a_erng), .spi_err_multi(a_emul),
      .qry_cpu(qry_cpu), .qry_num(qry_num), .qry_hit(a_hit));

   irq_target_bank #(.NUM_CPUS(1), .ALT_MODE(1'b0)) u_irq_target_bank_one (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(s_rvalid), .bus_rdata(s_rdata), .bus_err(s_err),
      .upd_valid(s_upd), .upd_hint(s_hint), .spi_valid(spi_valid), .spi_num(spi_num),
      .pend_valid(s_pend), .pend_target(s_ptgt), .pend_num(s_pnum),
      .spi_err_range(s_erng), .spi_err_multi(s_emul),
      .qry_cpu(qry_cpu), .qry_num(qry_num), .qry_hit(s_hit));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic w, input logic wd, input logic [2:0] cpu,
                         input logic [9:0] addr, input logic [31:0] data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = w; bus_word = wd;
      bus_cpu = cpu; bus_addr = addr; bus_wdata = data;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic spi_op(input logic [9:0] num);
      @(negedge clk);
      spi_valid = 1'b1; spi_num = num;
      @(negedge clk);
      spi_valid = 1'b0;
   endtask

   typedef struct packed {
      logic        wr;
      logic        word;
      logic [2:0]  cpu;
      logic [9:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b1,3'd0,10'd32,32'h0,32'h00000000,1'b0,4'd1},  // R1 reset value
      '{1'b0,1'b0,3'd0,10'd5, 32'h0,32'h00000001,1'b0,4'd2},  // R2
      '{1'b0,1'b0,3'd2,10'd31,32'h0,32'h00000004,1'b0,4'd2},  // R2
      '{1'b0,1'b1,3'd3,10'd9, 32'h0,32'h08080808,1'b0,4'd2},  // R2 word, R5 align
      '{1'b1,1'b0,3'd0,10'd33,32'h02,32'h0,1'b0,4'd4},        // R4 write
      '{1'b0,1'b0,3'd1,10'd33,32'h0,32'h00000002,1'b0,4'd4},  // R4
      '{1'b1,1'b1,3'd1,10'd42,32'h80402010,32'h0,1'b0,4'd5},  // R5 unaligned word
      '{1'b0,1'b1,3'd0,10'd40,32'h0,32'h80402010,1'b0,4'd5},  // R5
      '{1'b0,1'b0,3'd0,10'd42,32'h0,32'h00000040,1'b0,4'd5},  // R5 lane 2
      '{1'b1,1'b0,3'd2,10'd41,32'hAB03,32'h0,1'b0,4'd4},      // R4 only low byte
      '{1'b0,1'b1,3'd0,10'd43,32'h0,32'h80400310,1'b0,4'd5},  // R5
      '{1'b1,1'b0,3'd1,10'd3, 32'hFF,32'h0,1'b0,4'd3},        // R3
      '{1'b0,1'b0,3'd1,10'd3, 32'h0,32'h00000002,1'b0,4'd3},  // R3
      '{1'b1,1'b1,3'd0,10'd28,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
      '{1'b0,1'b1,3'd0,10'd28,32'h0,32'h01010101,1'b0,4'd3},  // R3
      '{1'b1,1'b0,3'd0,10'd70,32'h11,32'h0,1'b0,4'd6},        // R6
      '{1'b0,1'b0,3'd0,10'd70,32'h0,32'h00000000,1'b0,4'd6},  // R6
      '{1'b1,1'b0,3'd5,10'd32,32'h33,32'h0,1'b1,4'd8},        // R8
      '{1'b0,1'b0,3'd0,10'd32,32'h0,32'h00000000,1'b0,4'd8},  // R8
      '{1'b0,1'b1,3'd7,10'd32,32'h0,32'h00000000,1'b1,4'd8},  // R8
      '{1'b1,1'b1,3'd0,10'd60,32'h0F0E0D0C,32'h0,1'b0,4'd5},  // R5 top group
      '{1'b0,1'b1,3'd3,10'd60,32'h0,32'h0F0E0D0C,1'b0,4'd5},  // R5
      '{1'b0,1'b0,3'd0,10'd63,32'h0,32'h0000000F,1'b0,4'd4},  // R4
      '{1'b0,1'b1,3'd0,10'd64,32'h0,32'h00000000,1'b0,4'd6}   // R6
   };

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 outputs idle after reset
      chk("R1 rvalid", {31'b0, m_rvalid}, 32'd0);
      chk("R1 upd", {31'b0, m_upd}, 32'd0);
      chk("R1 pend", {31'b0, m_pend}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         bus_op(TBL[i].wr, TBL[i].word, TBL[i].cpu, TBL[i].addr, TBL[i].data);
         // R12 response strobe
         chk($sformatf("R12 row %0d rvalid", i), {31'b0, m_rvalid}, 32'd1);
         chk($sformatf("R%0d row %0d err", TBL[i].req, i), {31'b0, m_err}, {31'b0, TBL[i].err});
         if (!TBL[i].wr)
            chk($sformatf("R%0d row %0d rdata", TBL[i].req, i), m_rdata, TBL[i].exp);
      end

      // R7 update hint
      bus_op(1'b1, 1'b0, 3'd0, 10'd45, 32'h05);
      chk("R7 upd shared", {31'b0, m_upd}, 32'd1);
      chk("R7 hint", {24'b0, m_hint}, 32'd11);
      bus_op(1'b1, 1'b0, 3'd0, 10'd3, 32'h07);
      chk("R7 no upd private byte", {31'b0, m_upd}, 32'd0);
      bus_op(1'b1, 1'b1, 3'd0, 10'd29, 32'h0);
      chk("R7 no upd private word", {31'b0, m_upd}, 32'd0);
      bus_op(1'b1, 1'b1, 3'd2, 10'd33, 32'h00000200);
      chk("R7 upd word", {31'b0, m_upd}, 32'd1);
      chk("R7 hint word", {24'b0, m_hint}, 32'd8);
      bus_op(1'b1, 1'b0, 3'd6, 10'd40, 32'h55);
      chk("R7 R8 no upd bad cpu", {31'b0, m_upd}, 32'd0);
      bus_op(1'b0, 1'b1, 3'd0, 10'd40, 32'h0);
      chk("R8 field kept", m_rdata, 32'h80400310);

      // R2 number mode
      bus_op(1'b0, 1'b0, 3'd3, 10'd5, 32'h0);
      chk("R2 mask cpu3", m_rdata, 32'h08);
      chk("R2 number cpu3", a_rdata, 32'h03);
      bus_op(1'b0, 1'b1, 3'd2, 10'd0, 32'h0);
      chk("R2 number word", a_rdata, 32'h02020202);

      // R10 peripheral routing
      spi_op(10'd33);
      chk("R10 pend", {31'b0, m_pend}, 32'd1);
      chk("R10 target", {24'b0, m_ptgt}, 32'h02);
      chk("R10 num", {22'b0, m_pnum}, 32'd33);
      spi_op(10'd45);
      chk("R10 multi flag", {31'b0, m_emul}, 32'd1);
      chk("R10 multi no pend", {31'b0, m_pend}, 32'd0);
      chk("R10 number mode pend", {31'b0, a_pend}, 32'd1);
      chk("R10 number mode no multi", {31'b0, a_emul}, 32'd0);
      chk("R10 number mode target", {24'b0, a_ptgt}, 32'h05);
      spi_op(10'd36);
      chk("R10 zero mask pend", {31'b0, m_pend}, 32'd1);
      chk("R10 zero mask target", {24'b0, m_ptgt}, 32'h00);
      // R9 range
      spi_op(10'd5);
      chk("R9 low range", {31'b0, m_erng}, 32'd1);
      chk("R9 low no pend", {31'b0, m_pend}, 32'd0);
      spi_op(10'd64);
      chk("R9 high range", {31'b0, m_erng}, 32'd1);
      chk("R9 high no pend", {31'b0, m_pend}, 32'd0);

      // R11 queries
      qry_num = 10'd41; qry_cpu = 3'd1; #1;
      chk("R11 mask bit set", {31'b0, m_hit}, 32'd1);
      chk("R11 number mismatch", {31'b0, a_hit}, 32'd0);
      qry_cpu = 3'd2; #1;
      chk("R11 mask bit clear", {31'b0, m_hit}, 32'd0);
      qry_cpu = 3'd3; #1;
      chk("R11 number equal", {31'b0, a_hit}, 32'd1);
      qry_num = 10'd7; qry_cpu = 3'd2; #1;
      chk("R11 private line", {31'b0, m_hit}, 32'd1);
      qry_num = 10'd36; qry_cpu = 3'd0; #1;
      chk("R11 zero mask", {31'b0, m_hit}, 32'd0);
      chk("R11 single cpu", {31'b0, s_hit}, 32'd1);

      // R1 reset clears storage
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_op(1'b0, 1'b1, 3'd0, 10'd40, 32'h0);
      chk("R1 cleared after reset", m_rdata, 32'h0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule